// File: doc/BRIEF.md
# Four-Way Fully Associative Translation Buffer with Rank-Ordered Replacement

This block caches four virtual-to-physical page translations. Every slot holds a valid flag, a modified flag, a recency rank, a 4-bit virtual tag and a 4-bit physical frame. A requester offers a virtual page number and a read/write flag. The tag is compared against all four slots in parallel. On a match, the frame comes back with a hit flag one clock later.

On a mismatch, the block stops taking new lookups and raises a refill request that carries the missing page number. It then waits for the walker outside the block, which in practice answers after roughly a hundred cycles. The returned frame is written into a free slot if one exists. Otherwise it replaces the slot ranked least recent, and the replaced slot's tag and modified flag are reported so the page table can be brought up to date.

The ranks are always a permutation of 1 (newest) to 4 (oldest). Every hit or fill moves the touched slot to rank 1 and ages only the slots that were newer than it.

Top module: `tlb_fa`

## Requirements
- R1: After reset every slot is invalid, the ranks are 1..4, `ready` is high and `refill_req`, `resp_valid` and `evict_valid` are low.
- R2: A lookup is accepted when `req_valid` and `ready` are high at a clock edge. On a tag match, `resp_valid` is 1 on the next cycle with `resp_hit`=1 and the slot's frame on `resp_ppn`, and `ready` stays high.
- R3: On a mismatch, `refill_req` rises on the next cycle with `refill_vpn` equal to the looked-up page. It stays high, with `ready` low, until `refill_valid` is seen.
- R4: `refill_valid` seen while waiting produces, one cycle later, `resp_valid`=1, `resp_hit`=0 and `resp_ppn` equal to the refill frame. `ready` returns high, and a later lookup of that page hits.
- R5: While a slot is invalid, a fill uses an invalid slot, and `evict_valid` stays low.
- R6: With all slots valid, a fill replaces the slot of rank 4. `evict_valid` pulses in the same cycle as the fill response, with that slot's tag on `evict_tag` and its modified flag on `evict_dirty`.
- R7: After each hit or fill, the touched slot has rank 1, every slot with a lower rank than its old one gains 1, and the others keep theirs. The ranks remain a permutation of 1..4.
- R8: A write lookup sets the modified flag of the slot it hits or fills. A read does not clear it. The flag is observed through `evict_dirty`.
- R9: `req_valid` while `ready` is low, and `refill_valid` while no refill is pending, cause no response and change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | 4 | Virtual page number to translate |
| req_write | input | 1 | Lookup is a write access |
| ready | output | 1 | Block can accept a lookup |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Response came from a cached slot |
| resp_ppn | output | 4 | Physical page number |
| refill_req | output | 1 | Refill pending |
| refill_vpn | output | 4 | Page to be walked |
| refill_valid | input | 1 | Refill frame is present |
| refill_ppn | input | 4 | Frame supplied by the walker |
| evict_valid | output | 1 | A valid slot was replaced |
| evict_tag | output | 4 | Tag of the replaced slot |
| evict_dirty | output | 1 | Modified flag of the replaced slot |

## Verification
The fill response and the eviction report land on the same edge. Each miss with a full buffer therefore produces two events at once, and each event is compared against its own expected queue. Those expected values come from a rank model in the bench that follows the R7 rule.

A write that hits and its rank reshuffle also share one edge. A later eviction then reveals both whether the victim was correct and whether its modified flag survived. Lookup pulses sent during the long refill wait, and refill pulses sent while idle, must leave both queues untouched.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } tlb_state_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 4,
    parameter int IDX_W   = 2
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              key,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx
);

    logic [ENTRIES-1:0] match_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit = |match_vec;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2,
    parameter int RANK_W  = 3
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][RANK_W-1:0] rank,
    output logic [IDX_W-1:0]               victim_idx,
    output logic                           victim_valid
);

    localparam logic [RANK_W-1:0] OLDEST = RANK_W'(ENTRIES);

    logic               any_free;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   old_idx;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        old_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rank[i] == OLDEST) begin
                old_idx = IDX_W'(i);
            end
        end
    end

    assign victim_idx   = any_free ? free_idx : old_idx;
    assign victim_valid = !any_free;

endmodule

// File: rtl/tlb_rank_update.sv
module tlb_rank_update #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2,
    parameter int RANK_W  = 3
) (
    input  logic [ENTRIES-1:0][RANK_W-1:0] rank_in,
    input  logic [IDX_W-1:0]               touch_idx,
    output logic [ENTRIES-1:0][RANK_W-1:0] rank_out
);

    logic [RANK_W-1:0] touched_rank;

    assign touched_rank = rank_in[touch_idx];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
        always_comb begin
            if (touch_idx == IDX_W'(g)) begin
                rank_out[g] = RANK_W'(1);
            end else if (rank_in[g] < touched_rank) begin
                rank_out[g] = rank_in[g] + RANK_W'(1);
            end else begin
                rank_out[g] = rank_in[g];
            end
        end
    end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
    parameter int ENTRIES = 4,
    parameter int VTAG_W  = 4,
    parameter int PPN_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VTAG_W-1:0] req_vpn,
    input  logic              req_write,
    output logic              ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [PPN_W-1:0]  resp_ppn,
    output logic              refill_req,
    output logic [VTAG_W-1:0] refill_vpn,
    input  logic              refill_valid,
    input  logic [PPN_W-1:0]  refill_ppn,
    output logic              evict_valid,
    output logic [VTAG_W-1:0] evict_tag,
    output logic              evict_dirty
);
    import tlb_pkg::*;

    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int RANK_W = $clog2(ENTRIES + 1);

    typedef struct packed {
        tlb_state_e                         fsm;
        logic [ENTRIES-1:0]                 valid;
        logic [ENTRIES-1:0]                 dirty;
        logic [ENTRIES-1:0][RANK_W-1:0]     rank;
        logic [ENTRIES-1:0][VTAG_W-1:0]     tag;
        logic [ENTRIES-1:0][PPN_W-1:0]      ppn;
        logic [VTAG_W-1:0]                  pend_vpn;
        logic                               pend_wr;
        logic                               refill_req;
        logic                               resp_valid;
        logic                               resp_hit;
        logic [PPN_W-1:0]                   resp_ppn;
        logic                               evict_valid;
        logic [VTAG_W-1:0]                  evict_tag;
        logic                               evict_dirty;
    } tlb_st_t;

    function automatic tlb_st_t reset_state();
        tlb_st_t s;
        s = '0;
        s.fsm = ST_IDLE;
        for (int i = 0; i < ENTRIES; i++) begin
            s.rank[i] = RANK_W'(i + 1);
        end
        return s;
    endfunction

    tlb_st_t st_d, st_q;

    logic                            look_hit;
    logic [IDX_W-1:0]                look_idx;
    logic [IDX_W-1:0]                vic_idx;
    logic                            vic_valid;
    logic [IDX_W-1:0]                touch_idx;
    logic [ENTRIES-1:0][RANK_W-1:0]  rank_next;
    logic [ENTRIES-1:0][RANK_W-1:0]  rank_now;

    tlb_match #(
        .ENTRIES (ENTRIES),
        .TAG_W   (VTAG_W),
        .IDX_W   (IDX_W)
    ) u_match (
        .valid   (st_q.valid),
        .tags    (st_q.tag),
        .key     (req_vpn),
        .hit     (look_hit),
        .hit_idx (look_idx)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .RANK_W  (RANK_W)
    ) u_victim (
        .valid        (st_q.valid),
        .rank         (st_q.rank),
        .victim_idx   (vic_idx),
        .victim_valid (vic_valid)
    );

    assign touch_idx = (st_q.fsm == ST_IDLE) ? look_idx : vic_idx;

    tlb_rank_update #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .RANK_W  (RANK_W)
    ) u_rank (
        .rank_in   (st_q.rank),
        .touch_idx (touch_idx),
        .rank_out  (rank_next)
    );

    always_comb begin
        st_d             = st_q;
        st_d.resp_valid  = 1'b0;
        st_d.evict_valid = 1'b0;
        unique case (st_q.fsm)
            ST_IDLE: begin
                if (req_valid) begin
                    if (look_hit) begin
                        st_d.resp_valid = 1'b1;
                        st_d.resp_hit   = 1'b1;
                        st_d.resp_ppn   = st_q.ppn[look_idx];
                        st_d.rank       = rank_next;
                        if (req_write) begin
                            st_d.dirty[look_idx] = 1'b1;
                        end
                    end else begin
                        st_d.fsm        = ST_WAIT;
                        st_d.pend_vpn   = req_vpn;
                        st_d.pend_wr    = req_write;
                        st_d.refill_req = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (refill_valid) begin
                    st_d.fsm              = ST_IDLE;
                    st_d.refill_req       = 1'b0;
                    st_d.valid[vic_idx]   = 1'b1;
                    st_d.tag[vic_idx]     = st_q.pend_vpn;
                    st_d.ppn[vic_idx]     = refill_ppn;
                    st_d.dirty[vic_idx]   = st_q.pend_wr;
                    st_d.rank             = rank_next;
                    st_d.resp_valid       = 1'b1;
                    st_d.resp_hit         = 1'b0;
                    st_d.resp_ppn         = refill_ppn;
                    if (vic_valid) begin
                        st_d.evict_valid = 1'b1;
                        st_d.evict_tag   = st_q.tag[vic_idx];
                        st_d.evict_dirty = st_q.dirty[vic_idx];
                    end
                end
            end
            default: st_d = reset_state();
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign rank_now    = st_q.rank;
    assign ready       = (st_q.fsm == ST_IDLE);
    assign resp_valid  = st_q.resp_valid;
    assign resp_hit    = st_q.resp_hit;
    assign resp_ppn    = st_q.resp_ppn;
    assign refill_req  = st_q.refill_req;
    assign refill_vpn  = st_q.pend_vpn;
    assign evict_valid = st_q.evict_valid;
    assign evict_tag   = st_q.evict_tag;
    assign evict_dirty = st_q.evict_dirty;

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int ENTRIES = 4,
    parameter int RANK_W  = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic                           ready,
    input logic                           resp_valid,
    input logic                           resp_hit,
    input logic                           refill_req,
    input logic                           refill_valid,
    input logic                           evict_valid,
    input logic [ENTRIES-1:0][RANK_W-1:0] ranks
);

    logic [ENTRIES-1:0] seen;

    always_comb begin
        seen = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ranks[i] != '0 && int'(ranks[i]) <= ENTRIES) begin
                seen[int'(ranks[i]) - 1] = 1'b1;
            end
        end
    end

    // R7
    rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen == {ENTRIES{1'b1}});

    // R3
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && refill_req));

    // R3
    refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req && !refill_valid |=> refill_req);

    // R6
    evict_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> resp_valid && !resp_hit);

    // R2
    hit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_hit |-> $past(req_valid && ready));

    // R9
    wait_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req && req_valid |=> !(resp_valid && resp_hit));

endmodule

bind tlb_fa tlb_fa_chk #(
    .ENTRIES (ENTRIES),
    .RANK_W  (RANK_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .ready        (ready),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .refill_req   (refill_req),
    .refill_valid (refill_valid),
    .evict_valid  (evict_valid),
    .ranks        (rank_now)
);

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_vpn = '0;
    logic       req_write = 1'b0;
    logic       ready, resp_valid, resp_hit, refill_req, evict_valid, evict_dirty;
    logic [3:0] resp_ppn, refill_vpn, evict_tag;
    logic       walk_valid = 1'b0;
    logic       spur_valid = 1'b0;
    logic       refill_valid;
    logic [3:0] refill_ppn = '0;

    int tests = 0;
    int fails = 0;

    logic [4:0] exp_resp_q[$];
    logic [4:0] exp_ev_q[$];
    logic [3:0] exp_refill_vpn;

    bit         m_valid[4];
    bit         m_dirty[4];
    int         m_rank[4];
    logic [3:0] m_tag[4];
    logic [3:0] m_ppn[4];

    assign refill_valid = walk_valid | spur_valid;

    always #10 clk = ~clk;

    tlb_fa u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_write(req_write),
        .ready(ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_ppn(resp_ppn),
        .refill_req(refill_req), .refill_vpn(refill_vpn),
        .refill_valid(refill_valid), .refill_ppn(refill_ppn),
        .evict_valid(evict_valid), .evict_tag(evict_tag), .evict_dirty(evict_dirty)
    );

    function automatic logic [3:0] ppn_of(input logic [3:0] v);
        return v ^ 4'h9;
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (resp_valid) begin
                if (exp_resp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected response", {3'b0, resp_hit, resp_ppn}, 8'h0);
                end else begin
                    logic [4:0] e;
                    e = exp_resp_q.pop_front();
                    check({resp_hit, resp_ppn} == e, e[4] ? "R2 hit response" : "R4 fill response",
                          {3'b0, resp_hit, resp_ppn}, {3'b0, e});
                end
            end
            if (evict_valid) begin
                if (exp_ev_q.size() == 0) begin
                    check(1'b0, "R5 unexpected eviction", {3'b0, evict_dirty, evict_tag}, 8'h0);
                end else begin
                    logic [4:0] e;
                    e = exp_ev_q.pop_front();
                    check({evict_dirty, evict_tag} == e, "R6 R7 R8 eviction",
                          {3'b0, evict_dirty, evict_tag}, {3'b0, e});
                end
            end
        end
    end

    // page walker model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && refill_req) begin
                check(refill_vpn == exp_refill_vpn, "R3 refill page", {4'h0, refill_vpn}, {4'h0, exp_refill_vpn});
                check(!ready, "R3 ready low while waiting", {7'h0, ready}, 8'h0);
                repeat (100) @(negedge clk);
                refill_ppn = ppn_of(refill_vpn);
                walk_valid = 1'b1;
                @(negedge clk);
                walk_valid = 1'b0;
            end
        end
    end

    task automatic access(input logic [3:0] vpn, input bit wr, input bit intrude);
        int hidx = -1;
        int t;
        int old;
        for (int i = 0; i < 4; i++) if (m_valid[i] && m_tag[i] == vpn) hidx = i;
        if (hidx >= 0) begin
            exp_resp_q.push_back({1'b1, m_ppn[hidx]});
            if (wr) m_dirty[hidx] = 1'b1;
            t = hidx;
        end else begin
            t = -1;
            for (int i = 3; i >= 0; i--) if (!m_valid[i]) t = i;
            if (t < 0) begin
                for (int i = 0; i < 4; i++) if (m_rank[i] == 4) t = i;
                exp_ev_q.push_back({m_dirty[t], m_tag[t]});
            end
            exp_resp_q.push_back({1'b0, ppn_of(vpn)});
            m_valid[t] = 1'b1;
            m_tag[t]   = vpn;
            m_ppn[t]   = ppn_of(vpn);
            m_dirty[t] = wr;
            exp_refill_vpn = vpn;
        end
        old = m_rank[t];
        for (int j = 0; j < 4; j++) begin
            if (j == t) m_rank[j] = 1;
            else if (m_rank[j] < old) m_rank[j] = m_rank[j] + 1;
        end
        while (!ready) @(negedge clk);
        req_vpn = vpn;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude && !ready) begin
            // R9: lookup during refill wait must be dropped
            req_vpn = vpn ^ 4'hF;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!ready) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_valid[i] = 0; m_dirty[i] = 0; m_rank[i] = i + 1; m_tag[i] = '0; m_ppn[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ready == 1'b1, "R1 ready", {7'h0, ready}, 8'h1);
        check(refill_req == 1'b0, "R1 refill_req", {7'h0, refill_req}, 8'h0);
        check(resp_valid == 1'b0 && evict_valid == 1'b0, "R1 pulses", {6'h0, resp_valid, evict_valid}, 8'h0);

        // R5: fill four free slots
        access(4'h1, 0, 0);
        access(4'h2, 0, 0);
        access(4'h3, 0, 0);
        access(4'h4, 0, 0);
        // R2, R8: write hit, read hit
        access(4'h1, 1, 0);
        access(4'h3, 0, 0);
        access(4'h1, 0, 0);
        // R6, R7: evictions follow rank order
        access(4'h5, 0, 0);
        access(4'h4, 0, 0);
        access(4'h6, 0, 0);
        // R8: write on fill
        access(4'h7, 1, 0);
        access(4'h4, 0, 0);
        access(4'h5, 0, 0);
        access(4'h6, 0, 0);
        access(4'h8, 0, 1);
        // R9: spurious refill while idle
        @(negedge clk);
        spur_valid = 1'b1;
        @(negedge clk);
        spur_valid = 1'b0;
        check(resp_valid == 1'b0 && ready == 1'b1, "R9 idle refill ignored", {6'h0, resp_valid, ready}, 8'h1);
        access(4'hA, 0, 1);
        // mixed pattern
        for (int k = 0; k < 30; k++) begin
            access(4'((k * 7 + 3) % 11), (k % 3) == 0, (k % 5) == 0);
        end
        repeat (5) @(negedge clk);
        check(exp_resp_q.size() == 0, "R4 all responses seen", 8'(exp_resp_q.size()), 8'h0);
        check(exp_ev_q.size() == 0, "R6 all evictions seen", 8'(exp_ev_q.size()), 8'h0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule